// File: doc/BRIEF.md
# Register-Driven SPI Transfer Engine

This block is a SPI master that software runs one register write at a time. Software loads a transmit word and then writes a control word. That control write starts a shift of 1 to 32 bits. While the shift runs, the enable bit of the control word reads back as 1, so software polls that bit to learn when the transfer is done. The engine can keep the select line asserted after a transfer ends. This lets software build one flash command from several writes, for example an opcode byte, then an address word, then any number of data bytes. The select line is released only when a transfer marked as final completes.

A function-select register hands the SPI pins between software and a memory-mapped read path outside this block. The `sw_access` output tells that path who owns the pins. When software gives up access, the handover is not instant. The register keeps reading 1 until the engine is idle and a short settling window has passed.

The bus uses mode 0. The serial clock idles low. Output data changes on the falling edge and input data is sampled on the rising edge. Each half period of the serial clock lasts a fixed number of system clock cycles, set by a parameter.

Top module: `spi_xfer_engine`

## Requirements
- R1: Register addresses: 0 is function select, 1 is control, 2 is transmit data and 3 is receive data. A control write with bit 31 set and a bit count in bits 5:0 of 1 to 32 starts a transfer of exactly that many serial clock pulses. Bit 31 reads back as 1 from the cycle after the write until the transfer ends, then reads back as 0.
- R2: The transmit data is sent MSB first. Only its low N bits go out, starting with bit N-1. The serial clock idles low, and output data changes only while the serial clock is low.
- R3: Each bit is sampled on a rising serial clock edge and shifted in from bit 0. The receive register is cleared when a transfer starts. After an N-bit transfer it therefore holds the received bits right-aligned, with the first bit received in bit N-1 and zeros above it.
- R4: Control bit 28 selects the device. When it is clear at the start of a transfer, `spi_cs_n` stays high for that whole transfer.
- R5: Control bit 26 is the final flag. When it is set, `spi_cs_n` goes high on the same cycle that the transfer ends. When it is clear, `spi_cs_n` stays low into the next transfer.
- R6: A control write with bit 31 clear stops any transfer. On the next cycle the engine is idle, `spi_cs_n` is high and the serial clock is low.
- R7: A control write with bit 31 set is ignored while a transfer is running. The running transfer keeps its length.
- R8: Writing 1 to bit 0 of function select sets it to 1 at once. Writing 0 keeps it reading 1 while the engine is busy, then for HANDOFF further idle cycles, and only then clears it. `sw_access` follows this register.
- R9: Each high phase and each low phase of the serial clock lasts SCK_HALF system clock cycles.
- R10: A control write with bit 31 set and a bit count of 0 or more than 32 starts nothing. The select line does not assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, registered (valid one cycle later) |
| sw_access | output | 1 | Software owns the SPI pins |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Device select, active low |
| spi_miso | input | 1 | Serial data in |

## Verification
A start write takes effect on the clock edge that accepts it, so the busy bit appears in the registered read data one edge later. The bench sets the address at a falling edge and samples at the next falling edge, which catches that value. A transfer then takes 2·N·SCK_HALF cycles. The bench does not assume a fixed finish cycle: it polls the busy bit and checks the transmitted bits, the received word, the select line and the pulse count only once busy reads 0. The function-select release is checked twice: one read right after the write, and one read HANDOFF+2 cycles after the engine has gone idle. The phase length of the serial clock is measured between its own edges.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int REG_W = 32;
  localparam int LEN_W = $clog2(REG_W + 1);

  localparam logic [1:0] A_FSEL = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_TXD  = 2'd2;
  localparam logic [1:0] A_RXD  = 2'd3;

  localparam int B_EN   = 31;
  localparam int B_SEL  = 28;
  localparam int B_LAST = 26;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(SCK_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic [LEN_W-1:0] len,
  input  logic [REG_W-1:0] txd,
  input  logic             tick,
  input  logic             miso,
  output logic             busy,
  output logic             sck,
  output logic             mosi,
  output logic             last_edge,
  output logic [REG_W-1:0] rxd
);
  logic [REG_W-1:0] sh;
  logic [LEN_W-1:0] left;

  assign mosi      = sh[REG_W-1];
  assign last_edge = busy && tick && sck && (left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      sh   <= '0;
      rxd  <= '0;
      left <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      sck  <= 1'b0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      sck  <= 1'b0;
      sh   <= txd << (LEN_W'(REG_W) - len);
      rxd  <= '0;
      left <= len;
    end else if (busy && tick) begin
      if (!sck) begin
        sck <= 1'b1;
        rxd <= {rxd[REG_W-2:0], miso};
      end else begin
        sck <= 1'b0;
        if (left == LEN_W'(1)) begin
          busy <= 1'b0;
        end else begin
          left <= left - 1'b1;
          sh   <= sh << 1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int HANDOFF  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sw_access,
  output logic        spi_sck,
  output logic        spi_mosi,
  output logic        spi_cs_n,
  input  logic        spi_miso
);
  localparam int HCW = (HANDOFF > 1) ? $clog2(HANDOFF) : 1;

  logic             busy, tick, last_edge, cs_act;
  logic             ctrl_sel, ctrl_term, rel_pend;
  logic [LEN_W-1:0] ctrl_len;
  logic [HCW-1:0]   rel_cnt;
  logic [REG_W-1:0] txd_q, rxd, ctrl_rd;
  logic             ctrl_wr, fsel_wr, len_ok, start, abort;
  logic [LEN_W-1:0] len_w;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign fsel_wr = reg_wr && (reg_addr == A_FSEL);
  assign len_w   = reg_wdata[LEN_W-1:0];
  assign len_ok  = (len_w != '0) && (len_w <= LEN_W'(REG_W));
  assign start   = ctrl_wr && reg_wdata[B_EN] && len_ok && !busy;
  assign abort   = ctrl_wr && !reg_wdata[B_EN];
  assign spi_cs_n = !cs_act;

  spi_half_tick #(.SCK_HALF(SCK_HALF)) u_tick (
    .clk(clk), .rst(rst), .run(busy && !abort), .tick(tick)
  );

  spi_shift_core u_core (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .len(len_w),
    .txd(txd_q), .tick(tick), .miso(spi_miso), .busy(busy), .sck(spi_sck),
    .mosi(spi_mosi), .last_edge(last_edge), .rxd(rxd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q     <= '0;
      cs_act    <= 1'b0;
      ctrl_sel  <= 1'b0;
      ctrl_term <= 1'b0;
      ctrl_len  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_TXD) txd_q <= reg_wdata;
      if (abort) begin
        cs_act <= 1'b0;
      end else if (start) begin
        cs_act    <= reg_wdata[B_SEL];
        ctrl_sel  <= reg_wdata[B_SEL];
        ctrl_term <= reg_wdata[B_LAST];
        ctrl_len  <= len_w;
      end else if (last_edge && ctrl_term) begin
        cs_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_access <= 1'b0;
      rel_pend  <= 1'b0;
      rel_cnt   <= '0;
    end else if (fsel_wr && reg_wdata[0]) begin
      sw_access <= 1'b1;
      rel_pend  <= 1'b0;
    end else if (fsel_wr && sw_access) begin
      rel_pend <= 1'b1;
      rel_cnt  <= '0;
    end else if (rel_pend) begin
      if (busy) begin
        rel_cnt <= '0;
      end else if (rel_cnt == HCW'(HANDOFF - 1)) begin
        sw_access <= 1'b0;
        rel_pend  <= 1'b0;
      end else begin
        rel_cnt <= rel_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_rd               = '0;
    ctrl_rd[B_EN]         = busy;
    ctrl_rd[B_SEL]        = ctrl_sel;
    ctrl_rd[B_LAST]       = ctrl_term;
    ctrl_rd[LEN_W-1:0]    = ctrl_len;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_FSEL:  reg_rdata <= {31'd0, sw_access};
        A_CTRL:  reg_rdata <= ctrl_rd;
        A_TXD:   reg_rdata <= txd_q;
        default: reg_rdata <= rxd;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        sck,
  input logic        mosi,
  input logic        cs_n,
  input logic        sw_access,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        last_edge,
  input logic        term
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !busy |-> !sck); // R2
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst) (sck && $past(sck)) |-> $stable(mosi)); // R2
  AST_FINAL_RELEASE: assert property (@(posedge clk) disable iff (rst) (last_edge && term) |=> cs_n); // R5
  AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (rst) (reg_wr && reg_addr == 2'd1 && !reg_wdata[31]) |=> (cs_n && !busy && !sck)); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst) (busy && !last_edge && reg_wr && reg_addr == 2'd1 && reg_wdata[31]) |=> busy); // R7
  AST_FSEL_HOLD: assert property (@(posedge clk) disable iff (rst) (sw_access && busy) |=> sw_access); // R8
endmodule

bind spi_xfer_engine spi_xfer_engine_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .sck(spi_sck), .mosi(spi_mosi),
  .cs_n(spi_cs_n), .sw_access(sw_access), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .last_edge(last_edge),
  .term(ctrl_term)
);

// File: tb/spi_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;
  localparam int SCK_HALF = 2;
  localparam int HANDOFF  = 4;
  localparam logic [31:0] EN = 32'h8000_0000, SEL = 32'h1000_0000, FIN = 32'h0400_0000;

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sw_access, spi_sck, spi_mosi, spi_cs_n, spi_miso;

  int checks = 0, fails = 0;
  int rises = 0, cs_falls = 0, cs_rises = 0;
  logic [31:0] slv_tx = '0, slv_rx = '0;

  always #2.5 clk = ~clk;

  spi_xfer_engine #(.SCK_HALF(SCK_HALF), .HANDOFF(HANDOFF)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_access(sw_access),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .spi_miso(spi_miso)
  );

  assign spi_miso = slv_tx[31];
  always @(posedge spi_sck) begin rises++; slv_rx <= {slv_rx[30:0], spi_mosi}; end
  always @(negedge spi_sck) slv_tx <= slv_tx << 1;
  always @(negedge spi_cs_n) cs_falls++;
  always @(posedge spi_cs_n) cs_rises++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd1, v);
      if (!v[31]) return;
    end
  endtask

  task automatic clear_mon(input logic [31:0] slave);
    rises = 0; cs_falls = 0; cs_rises = 0; slv_rx = '0; slv_tx = slave;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd1, v); chk("R1 reset ctrl", v, 32'h0);
    rd(2'd0, v); chk("R8 reset fsel", v, 32'h0);
    chk("R5 reset cs_n", {31'd0, spi_cs_n}, 32'h1);
    chk("R2 reset sck", {31'd0, spi_sck}, 32'h0);
  endtask

  task automatic t_word32();
    logic [31:0] v;
    clear_mon(32'h1234_5678);
    wr(2'd2, 32'hA5C3_0F81);
    wr(2'd1, EN | SEL | FIN | 32'd32);
    rd(2'd1, v); chk("R1 busy after start", {31'd0, v[31]}, 32'h1);
    wait_idle();
    chk("R1 pulses 32", rises, 32);
    chk("R2 sent msb first", slv_rx, 32'hA5C3_0F81);
    rd(2'd3, v); chk("R3 rx word", v, 32'h1234_5678);
    chk("R5 released after final", {31'd0, spi_cs_n}, 32'h1);
  endtask

  task automatic t_split();
    logic [31:0] v;
    clear_mon(32'hC300_0000);
    wr(2'd2, 32'hFFFF_FF9B);
    wr(2'd1, EN | SEL | 32'd8);
    wait_idle();
    chk("R2 low byte only", slv_rx, 32'h0000_009B);
    rd(2'd3, v); chk("R3 byte right aligned", v, 32'h0000_00C3);
    chk("R5 held without final", {31'd0, spi_cs_n}, 32'h0);
    slv_tx = 32'h5A6B_7C00; slv_rx = '0; rises = 0;
    wr(2'd2, 32'h00AB_CDEF);
    wr(2'd1, EN | SEL | FIN | 32'd24);
    wait_idle();
    chk("R2 24 bits", slv_rx, 32'h00AB_CDEF);
    rd(2'd3, v); chk("R3 24-bit aligned", v, 32'h005A_6B7C);
    chk("R5 single select window", cs_falls * 16 + cs_rises, 32'h11);
    clear_mon(32'h0);
    wr(2'd1, EN | SEL | FIN | 32'd8);
    wait_idle();
    rd(2'd3, v); chk("R3 cleared at start", v, 32'h0);
  endtask

  task automatic t_nosel();
    clear_mon(32'hFFFF_FFFF);
    wr(2'd2, 32'h0000_1234);
    wr(2'd1, EN | FIN | 32'd16);
    wait_idle();
    chk("R4 no select", cs_falls, 0);
    chk("R4 still shifts", rises, 16);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    clear_mon(32'h0);
    wr(2'd1, EN | SEL | 32'd32);
    repeat (20) @(negedge clk);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R6 idle after stop", {31'd0, v[31]}, 32'h0);
    chk("R6 cs released", {31'd0, spi_cs_n}, 32'h1);
    chk("R6 sck low", {31'd0, spi_sck}, 32'h0);
  endtask

  task automatic t_ignore();
    clear_mon(32'h0);
    wr(2'd1, EN | SEL | FIN | 32'd32);
    repeat (10) @(negedge clk);
    wr(2'd1, EN | SEL | FIN | 32'd8);
    wait_idle();
    chk("R7 length kept", rises, 32);
  endtask

  task automatic t_badlen();
    logic [31:0] v;
    clear_mon(32'h0);
    wr(2'd1, EN | SEL | FIN | 32'd0);
    rd(2'd1, v); chk("R10 zero length no start", {31'd0, v[31]}, 32'h0);
    wr(2'd1, EN | SEL | FIN | 32'd40);
    rd(2'd1, v); chk("R10 long length no start", {31'd0, v[31]}, 32'h0);
    repeat (10) @(negedge clk);
    chk("R10 no pulses", rises, 0);
    chk("R10 no select", cs_falls, 0);
  endtask

  task automatic t_rate();
    realtime t0, t1, t2;
    clear_mon(32'h0);
    wr(2'd1, EN | SEL | FIN | 32'd8);
    @(posedge spi_sck); t0 = $realtime;
    @(negedge spi_sck); t1 = $realtime;
    @(posedge spi_sck); t2 = $realtime;
    chk("R9 high phase", int'((t1 - t0) / 5.0), SCK_HALF);
    chk("R9 low phase", int'((t2 - t1) / 5.0), SCK_HALF);
    wait_idle();
  endtask

  task automatic t_fsel();
    logic [31:0] v;
    wr(2'd0, 32'h1);
    rd(2'd0, v); chk("R8 grant", v, 32'h1);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R8 held during handover", v, 32'h1);
    repeat (HANDOFF + 2) @(negedge clk);
    rd(2'd0, v); chk("R8 released", v, 32'h0);
    chk("R8 port follows", {31'd0, sw_access}, 32'h0);
    wr(2'd0, 32'h1);
    wr(2'd1, EN | SEL | FIN | 32'd32);
    wr(2'd0, 32'h0);
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk("R8 held while busy", v, 32'h1);
    wait_idle();
    repeat (HANDOFF + 2) @(negedge clk);
    rd(2'd0, v); chk("R8 released after idle", v, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_word32();
    t_split();
    t_nosel();
    t_abort();
    t_ignore();
    t_badlen();
    t_rate();
    t_fsel();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule